// File: doc/BRIEF.md
# Trap Entry Stack-Push Sequencer

This block carries out the entry sequence that precedes a trap service routine. A single-cycle start request arrives from a software trap or from an injected hardware trap. The block then captures the processor context: the status word, the code segment, the instruction pointer, the stack pointer, the trap number and the vector segment. It writes the saved words to a downward-growing system stack through a word-wide write port, one word per cycle. When the writes are finished, it presents the branch target, the new code segment and the updated status word for one cycle.

The two entry kinds differ only in the status word they produce. A software trap returns the status word unchanged, so the priority level and the register bank select stay as they were. A hardware trap sets the priority-level field to all ones, which shuts out every interrupt and every DMA grant, and sets the bank field to the global bank. When segmented addressing is active, the code segment word is saved between the status word and the instruction pointer. Otherwise it is left out.

Top module: `trapEntrySeq`

## Requirements
- R1: During and right after reset, busy, done and stkWrEn are low, spOut is zero, and ipOut, cspOut and statusOut are zero.
- R2: With segMode high at the start, three writes follow in consecutive cycles, beginning in the cycle after the start: the status word, then the code segment zero-extended to the word width, then the instruction pointer.
- R3: With segMode low at the start, only two writes follow in consecutive cycles: the status word, then the instruction pointer.
- R4: spOut shows the captured stack pointer in the first write cycle and drops by 2 (bytes) after every write. Each write address equals spOut minus 2 in that cycle.
- R5: The words written are the values on statusIn, cspIn and ipIn in the start cycle. Later changes on those inputs have no effect.
- R6: In the cycle after the last write, done is high for exactly one cycle, with ipOut = trapNum shifted left by 2 (zero-extended) and cspOut = vecSegIn as captured at the start. Outside that cycle, ipOut, cspOut and statusOut are zero.
- R7: For a software trap, statusOut in the done cycle equals the captured status word.
- R8: For a hardware trap, statusOut in the done cycle equals the captured status word with bits [15:12] (priority level) set to 4'hF and bits [9:8] (bank select) set to the global bank code 2'b00.
- R9: busy is high from the first write cycle through the done cycle. A start request during that time, including the done cycle, is ignored.
- R10: When startSw and startHw are both high in the same cycle, the sequence runs as a hardware trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startSw | input | 1 | Software trap start request |
| startHw | input | 1 | Hardware trap start request |
| segMode | input | 1 | Segmented addressing active |
| trapNum | input | 7 | Trap number |
| statusIn | input | 16 | Current status word |
| cspIn | input | 8 | Current code segment |
| ipIn | input | 16 | Return instruction pointer |
| spIn | input | 16 | Current stack pointer (byte address) |
| vecSegIn | input | 8 | Vector segment value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Branch target valid (one cycle) |
| stkWrEn | output | 1 | Stack write strobe |
| stkWrAddr | output | 16 | Stack write byte address |
| stkWrData | output | 16 | Stack write word |
| spOut | output | 16 | Working stack pointer |
| ipOut | output | 16 | New instruction pointer |
| cspOut | output | 8 | New code segment |
| statusOut | output | 16 | New status word |

## Verification
The hardest case to reach is a start request that comes in while a sequence is still running. The request must be dropped even when it lands in the done cycle, and every context input must keep changing after capture, so that any late sampling shows up in the stack data. The stimulus drives fresh random values onto every context input in every cycle. It raises start requests at scripted points that fall inside and at the tail of running sequences, and then at random. A reference model built from queues predicts every output cycle by cycle.

// File: rtl/trapSeqPkg.sv
package trapSeqPkg;
  typedef enum logic [1:0] {SEL_PSW = 2'd0, SEL_CSP = 2'd1, SEL_IP = 2'd2} pushSel_e;

  typedef struct packed {
    logic     capture;
    logic     push;
    pushSel_e sel;
    logic     branch;
  } seqStrobes_t;
endpackage

// File: rtl/trapSeqCtrl.sv
module trapSeqCtrl
  import trapSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startSw,
  input  logic        startHw,
  input  logic        segMode,
  output seqStrobes_t strobes,
  output logic        busy,
  output logic        done
);
  typedef enum logic [2:0] {S_IDLE, S_PSW, S_CSP, S_IP, S_BR} state_e;
  state_e state;
  logic   segQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      segQ  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (startSw || startHw) begin
          state <= S_PSW;
          segQ  <= segMode;
        end
        S_PSW:   state <= segQ ? S_CSP : S_IP;
        S_CSP:   state <= S_IP;
        S_IP:    state <= S_BR;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.capture = (state == S_IDLE) && (startSw || startHw);
    strobes.push    = (state == S_PSW) || (state == S_CSP) || (state == S_IP);
    strobes.branch  = (state == S_BR);
    case (state)
      S_CSP:   strobes.sel = SEL_CSP;
      S_IP:    strobes.sel = SEL_IP;
      default: strobes.sel = SEL_PSW;
    endcase
    busy = (state != S_IDLE);
    done = strobes.branch;
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R2
  push_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.push && strobes.sel == SEL_CSP) |-> ($past(strobes.push) && $past(strobes.sel) == SEL_PSW));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobes.capture);
endmodule

// File: rtl/trapSeqData.sv
module trapSeqData
  import trapSeqPkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SEG_W       = 8,
  parameter int TRAPNUM_W   = 7,
  parameter int LEVEL_LSB   = 12,
  parameter int LEVEL_W     = 4,
  parameter int BANK_LSB    = 8,
  parameter int BANK_W      = 2,
  parameter int GLOBAL_BANK = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobes_t          strobes,
  input  logic                 startHw,
  input  logic [TRAPNUM_W-1:0] trapNum,
  input  logic [WORD_W-1:0]    statusIn,
  input  logic [SEG_W-1:0]     cspIn,
  input  logic [WORD_W-1:0]    ipIn,
  input  logic [WORD_W-1:0]    spIn,
  input  logic [SEG_W-1:0]     vecSegIn,
  output logic                 stkWrEn,
  output logic [WORD_W-1:0]    stkWrAddr,
  output logic [WORD_W-1:0]    stkWrData,
  output logic [WORD_W-1:0]    spOut,
  output logic [WORD_W-1:0]    ipOut,
  output logic [SEG_W-1:0]     cspOut,
  output logic [WORD_W-1:0]    statusOut
);
  localparam int STEP  = WORD_W / 8;
  localparam int VEC_W = TRAPNUM_W + 2;
  localparam logic [WORD_W-1:0] FIELD_MASK =
    (((WORD_W'(1) << LEVEL_W) - 1) << LEVEL_LSB) | (((WORD_W'(1) << BANK_W) - 1) << BANK_LSB);

  logic [WORD_W-1:0]    pswQ, ipQ, spQ;
  logic [SEG_W-1:0]     cspQ, vecQ;
  logic [TRAPNUM_W-1:0] numQ;
  logic                 hwQ;
  logic [WORD_W-1:0]    newPsw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pswQ <= '0; ipQ <= '0; spQ <= '0;
      cspQ <= '0; vecQ <= '0; numQ <= '0; hwQ <= 1'b0;
    end else if (strobes.capture) begin
      pswQ <= statusIn;
      ipQ  <= ipIn;
      spQ  <= spIn;
      cspQ <= cspIn;
      vecQ <= vecSegIn;
      numQ <= trapNum;
      hwQ  <= startHw;
    end else if (strobes.push) begin
      spQ <= spQ - WORD_W'(STEP);
    end
  end

  always_comb begin
    newPsw = pswQ;
    if (hwQ) begin
      newPsw[LEVEL_LSB +: LEVEL_W] = '1;
      newPsw[BANK_LSB +: BANK_W]   = BANK_W'(GLOBAL_BANK);
    end
    case (strobes.sel)
      SEL_CSP: stkWrData = WORD_W'(cspQ);
      SEL_IP:  stkWrData = ipQ;
      default: stkWrData = pswQ;
    endcase
    stkWrEn   = strobes.push;
    stkWrAddr = spQ - WORD_W'(STEP);
    spOut     = spQ;
    ipOut     = strobes.branch ? WORD_W'({numQ, 2'b00}) : '0;
    cspOut    = strobes.branch ? vecQ : '0;
    statusOut = strobes.branch ? newPsw : '0;
  end

  initial begin
    assert (VEC_W <= WORD_W) else $error("vector offset wider than word");
  end

  // R4
  sp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stkWrEn |=> (spOut == $past(spOut) - WORD_W'(STEP)));

  // R5
  context_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stkWrEn && strobes.sel != SEL_PSW) |-> $stable(pswQ));

  // R7
  other_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.branch |-> ((statusOut & ~FIELD_MASK) == (pswQ & ~FIELD_MASK)));
endmodule

// File: rtl/trapEntrySeq.sv
module trapEntrySeq
  import trapSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startSw,
  input  logic        startHw,
  input  logic        segMode,
  input  logic [6:0]  trapNum,
  input  logic [15:0] statusIn,
  input  logic [7:0]  cspIn,
  input  logic [15:0] ipIn,
  input  logic [15:0] spIn,
  input  logic [7:0]  vecSegIn,
  output logic        busy,
  output logic        done,
  output logic        stkWrEn,
  output logic [15:0] stkWrAddr,
  output logic [15:0] stkWrData,
  output logic [15:0] spOut,
  output logic [15:0] ipOut,
  output logic [7:0]  cspOut,
  output logic [15:0] statusOut
);
  seqStrobes_t strobes;

  trapSeqCtrl ctrl (
    .clk(clk), .rstN(rstN), .startSw(startSw), .startHw(startHw),
    .segMode(segMode), .strobes(strobes), .busy(busy), .done(done)
  );

  trapSeqData #(
    .WORD_W(16), .SEG_W(8), .TRAPNUM_W(7), .LEVEL_LSB(12), .LEVEL_W(4),
    .BANK_LSB(8), .BANK_W(2), .GLOBAL_BANK(0)
  ) data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .startHw(startHw),
    .trapNum(trapNum), .statusIn(statusIn), .cspIn(cspIn), .ipIn(ipIn),
    .spIn(spIn), .vecSegIn(vecSegIn), .stkWrEn(stkWrEn),
    .stkWrAddr(stkWrAddr), .stkWrData(stkWrData), .spOut(spOut),
    .ipOut(ipOut), .cspOut(cspOut), .statusOut(statusOut)
  );

  // R10
  both_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startSw && startHw) |=> busy);
endmodule

// File: tb/trapEntrySeq_test.sv
module trapEntrySeq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startSw = 1'b0, startHw = 1'b0, segMode = 1'b0;
  logic [6:0]  trapNum = '0;
  logic [15:0] statusIn = '0, ipIn = '0, spIn = '0;
  logic [7:0]  cspIn = '0, vecSegIn = '0;
  logic busy, done, stkWrEn;
  logic [15:0] stkWrAddr, stkWrData, spOut, ipOut, statusOut;
  logic [7:0]  cspOut;

  always #4 clk = ~clk;

  trapEntrySeq uut (
    .clk(clk), .rstN(rstN), .startSw(startSw), .startHw(startHw),
    .segMode(segMode), .trapNum(trapNum), .statusIn(statusIn), .cspIn(cspIn),
    .ipIn(ipIn), .spIn(spIn), .vecSegIn(vecSegIn), .busy(busy), .done(done),
    .stkWrEn(stkWrEn), .stkWrAddr(stkWrAddr), .stkWrData(stkWrData),
    .spOut(spOut), .ipOut(ipOut), .cspOut(cspOut), .statusOut(statusOut)
  );

  typedef struct {
    bit busy, done, wr;
    logic [15:0] addr, data, sp, ip, status;
    logic [7:0] csp;
    string dataTag, statTag;
  } expItem_t;

  expItem_t expQ[$];
  int vectors = 0, miscompares = 0;
  logic [15:0] lastSp = '0;
  bit prevBusy = 0;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic enqueue(bit hw, bit seg, logic [6:0] num, logic [15:0] st,
                         logic [7:0] cs, logic [15:0] ip, logic [15:0] sp,
                         logic [7:0] vec, bit both);
    expItem_t it;
    logic [15:0] s = sp;
    it = '{busy:1, done:0, wr:1, addr:s-2, data:st, sp:s, ip:0, status:0, csp:0,
           dataTag:"R2 R5", statTag:"R6"};
    expQ.push_back(it); s -= 2;
    if (seg) begin
      it = '{busy:1, done:0, wr:1, addr:s-2, data:{8'h00, cs}, sp:s, ip:0, status:0, csp:0,
             dataTag:"R2 R5", statTag:"R6"};
      expQ.push_back(it); s -= 2;
    end
    it = '{busy:1, done:0, wr:1, addr:s-2, data:ip, sp:s, ip:0, status:0, csp:0,
           dataTag:(seg ? "R2 R5" : "R3 R5"), statTag:"R6"};
    expQ.push_back(it); s -= 2;
    it.busy = 1; it.done = 1; it.wr = 0; it.sp = s;
    it.ip = {7'd0, num, 2'b00}; it.csp = vec; it.status = st;
    if (hw) begin it.status[15:12] = 4'hF; it.status[9:8] = 2'b00; end
    it.statTag = both ? "R10" : (hw ? "R8" : "R7");
    expQ.push_back(it);
  endtask

  task automatic cmp(string tag, string name, logic [15:0] act, logic [15:0] exp, inout bit bad);
    if (act !== exp) begin
      $display("FAIL %s %s: actual %h expected %h", tag, name, act, exp);
      bad = 1;
    end
  endtask

  task automatic check_cycle();
    expItem_t e;
    bit bad = 0;
    if (expQ.size() > 0) e = expQ.pop_front();
    else e = '{busy:0, done:0, wr:0, addr:0, data:0, sp:lastSp, ip:0, status:0, csp:0,
               dataTag:"R2", statTag:"R6"};
    lastSp = e.sp;
    vectors++;
    cmp("R9", "busy", 16'(busy), 16'(e.busy), bad);
    cmp("R6", "done", 16'(done), 16'(e.done), bad);
    cmp("R2", "stkWrEn", 16'(stkWrEn), 16'(e.wr), bad);
    cmp("R4", "spOut", spOut, e.sp, bad);
    if (e.wr) begin
      cmp("R4", "stkWrAddr", stkWrAddr, e.addr, bad);
      cmp(e.dataTag, "stkWrData", stkWrData, e.data, bad);
    end
    cmp("R6", "ipOut", ipOut, e.ip, bad);
    cmp("R6", "cspOut", 16'(cspOut), 16'(e.csp), bad);
    cmp(e.statTag, "statusOut", statusOut, e.status, bad);
    if (bad) miscompares++;
    prevBusy = e.busy;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    miscompares++;
    finish_run();
  end

  initial begin
    // R1: check during reset and just after release
    repeat (3) @(negedge clk);
    vectors++;
    if (busy !== 0 || done !== 0 || stkWrEn !== 0 || spOut !== 0 ||
        ipOut !== 0 || cspOut !== 0 || statusOut !== 0) begin
      $display("FAIL R1 reset: actual busy=%b done=%b wr=%b sp=%h expected all zero",
               busy, done, stkWrEn, spOut);
      miscompares++;
    end
    rstN = 1'b1;
    for (int cyc = 0; cyc < 2500; cyc++) begin
      @(negedge clk);
      check_cycle();
      statusIn = 16'($urandom); cspIn = 8'($urandom); ipIn = 16'($urandom);
      spIn = 16'($urandom); vecSegIn = 8'($urandom); trapNum = 7'($urandom);
      segMode = 1'($urandom);
      startSw = 0; startHw = 0;
      case (cyc)
        0:  begin startSw = 1; segMode = 1; end        // R2 R7
        10: begin startSw = 1; segMode = 0; end        // R3 R7
        20: begin startHw = 1; segMode = 1; end        // R2 R8
        30: begin startHw = 1; segMode = 0; end        // R3 R8
        40: begin startSw = 1; startHw = 1; end        // R10
        42, 43: startHw = 1;                           // R9 ignored while busy
        50: begin startSw = 1; segMode = 0; end
        53: startSw = 1;                               // R9 lands in done cycle
        60: begin startHw = 1; trapNum = 7'h7F; spIn = 16'h0002; end // R4 R6 wrap
        default: if (cyc > 70) begin
          startSw = ($urandom % 4) == 0;
          startHw = ($urandom % 5) == 0;
        end
      endcase
      if ((startSw || startHw) && expQ.size() == 0 && !prevBusy)
        enqueue(startHw, segMode, trapNum, statusIn, cspIn, ipIn, spIn, vecSegIn,
                startSw && startHw);
    end
    finish_run();
  end
endmodule